// File: doc/BRIEF.md
# Logic-Only Radix-4 Carry-Save Multiplier

This block multiplies two 32-bit operands using logic only. It uses no dedicated multiplier cells and holds no state. The multiplier operand is cut into sixteen two-bit fields. Each field picks zero, one, two or three times the multiplicand. The picked value, moved left to the field's weight, becomes one partial product. The sixteen partial products go into a tree of three-input carry-save adders. The tree shrinks them level by level until two words are left. One ripple-free carry-propagate addition then gives the result.

Only the least significant 32 bits of the product leave the block. A truncated product does not depend on how the operands are interpreted, so the same word serves signed and unsigned multiplication. The block drops into a processor datapath where a low-word multiply result is written straight back. The outputs settle in the same cycle as the inputs.

Top module: `wallace_mul32`

## Requirements
- R1: `prod_o` equals the unsigned product of `a_i` and `b_i` taken modulo 2^32.
- R2: When both operands are read as two's-complement numbers, `prod_o` equals the low 32 bits of their signed product.
- R3: The block holds no state. A new operand pair shows its result at `prod_o` without any clock edge in between.
- R4: When either operand is zero, `prod_o` is zero.
- R5: When `b_i` is 2^k, `prod_o` equals `a_i` shifted left by k, and bits shifted past bit 31 are lost.
- R6: A two-bit field of `b_i` with the value 3 adds three times `a_i` at that field's weight. For example, `b_i` = 3 gives 3·`a_i` mod 2^32.
- R7: The carry-save adder cell has three inputs. Its sum output is the bitwise XOR of the three inputs. Its carry output is the bitwise majority of the three inputs, moved up one bit position, and its top majority bit is dropped. With 8-bit inputs 40, 41 and 42 it gives a sum of 43 and a carry of 80.
- R8: Product bits above bit 31 are discarded. For example, 0xFFFFFFFF·0xFFFFFFFF gives 1, and 0x80000000·2 gives 0.
- R9: Each two-bit field of `b_i` (bits 2i+1 down to 2i, for i = 0 to 15) selects its multiple on its own. A `b_i` whose fields take every value from 0 to 3 in a repeating pattern gives the exact low-word product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier, read two bits at a time |
| prod_o | output | 32 | Least significant word of a_i·b_i |

## Verification
The stimulus mixes several kinds of operands:
- Uniform random pairs exercise every field value at every position, so they expose a wrong shift, mux choice or tree wiring.
- Signed pairs with negative values show that the truncated word does not depend on the interpretation.
- Edge values (0, 1, all ones, 0x80000000, 0x7FFFFFFF) and powers of two put carries at the truncation boundary. A top adder bit that is dropped or kept by mistake shows up here.
- Repeating field patterns such as 0xE4E4E4E4 make the 3A path differ from the A and 2A paths.

The adder cell is also driven on its own with the 40/41/42 vector, so that the split into a sum word and a carry word is checked and not only their total.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

    // Value of one two-bit field of the multiplier operand
    typedef enum logic [1:0] {
        MSEL_ZERO  = 2'd0,
        MSEL_ONE   = 2'd1,
        MSEL_TWO   = 2'd2,
        MSEL_THREE = 2'd3
    } msel_e;

    // Number of words present after `lvl` levels of 3:2 reduction
    function automatic int tree_cnt(input int n0, input int lvl);
        int n;
        n = n0;
        for (int k = 0; k < lvl; k++) begin
            n = 2 * (n / 3) + (n % 3);
        end
        return n;
    endfunction

    // Index of the first node of level `lvl` in the flat node pool
    function automatic int tree_base(input int n0, input int lvl);
        int b;
        b = 0;
        for (int k = 0; k < lvl; k++) begin
            b = b + tree_cnt(n0, k);
        end
        return b;
    endfunction

    // Number of reduction levels until two words remain
    function automatic int tree_depth(input int n0);
        int n;
        int d;
        n = n0;
        d = 0;
        while (n > 2) begin
            n = 2 * (n / 3) + (n % 3);
            d++;
        end
        return d;
    endfunction

    // Total node count, including the final two words
    function automatic int tree_nodes(input int n0);
        return tree_base(n0, tree_depth(n0)) + 2;
    endfunction

endpackage

// File: rtl/wmul_csa.sv
module wmul_csa #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    logic [W-1:0] maj;

    assign sum_o = x_i ^ y_i ^ z_i;
    assign maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    assign cry_o = {maj[W-2:0], 1'b0};

    // The two outputs together carry the same value as the three inputs (mod 2^W)
    always_comb begin
        AST_CSA_CONSERVE: assert (W'(sum_o + cry_o) == W'(x_i + y_i + z_i)); // R7
    end
endmodule

// File: rtl/wmul_ppgen.sv
module wmul_ppgen
    import wmul_pkg::*;
#(
    parameter int W   = 32,
    parameter int NPP = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] pp_o [NPP]
);
    // Shared multiples of the multiplicand
    logic [W-1:0] mult [4];

    assign mult[0] = '0;
    assign mult[1] = a_i;
    assign mult[2] = a_i << 1;
    assign mult[3] = a_i + (a_i << 1);

    always_comb begin
        AST_TRIPLE_SPLIT: assert (W'(mult[3] - mult[1]) == mult[2]); // R6
    end

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        msel_e sel;
        assign sel     = msel_e'(b_i[2*i +: 2]);
        assign pp_o[i] = mult[sel] << (2 * i);

        always_comb begin
            if (sel == MSEL_ZERO) begin
                AST_PP_ZERO_FIELD: assert (pp_o[i] == '0); // R4
            end
        end
    end
endmodule

// File: rtl/wmul_tree.sv
module wmul_tree
    import wmul_pkg::*;
#(
    parameter int W   = 32,
    parameter int NIN = 16
) (
    input  logic [W-1:0] in_i  [NIN],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    localparam int DEPTH = tree_depth(NIN);
    localparam int NODES = tree_nodes(NIN);

    logic [W-1:0] node [NODES];

    for (genvar j = 0; j < NIN; j++) begin : g_leaf
        assign node[j] = in_i[j];
    end

    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
        localparam int CNT  = tree_cnt(NIN, l);
        localparam int BASE = tree_base(NIN, l);
        localparam int NXT  = BASE + CNT;
        localparam int NGRP = CNT / 3;
        localparam int NREM = CNT % 3;

        for (genvar g = 0; g < NGRP; g++) begin : g_csa
            wmul_csa #(.W(W)) u_csa (
                .x_i   (node[BASE + 3*g]),
                .y_i   (node[BASE + 3*g + 1]),
                .z_i   (node[BASE + 3*g + 2]),
                .sum_o (node[NXT + 2*g]),
                .cry_o (node[NXT + 2*g + 1])
            );
        end

        for (genvar r = 0; r < NREM; r++) begin : g_pass
            assign node[NXT + 2*NGRP + r] = node[BASE + 3*NGRP + r];
        end
    end

    assign sum_o = node[NODES-2];
    assign cry_o = node[NODES-1];

    // The two surviving words add up to the sum of all partial products
    logic [W-1:0] in_total;
    always_comb begin
        in_total = '0;
        for (int k = 0; k < NIN; k++) begin
            in_total = in_total + in_i[k];
        end
        AST_TREE_CONSERVE: assert (W'(sum_o + cry_o) == in_total); // R1
    end
endmodule

// File: rtl/wallace_mul32.sv
module wallace_mul32
    import wmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o
);
    localparam int NPP = W / 2;

    logic [W-1:0] pp [NPP];
    logic [W-1:0] red_s;
    logic [W-1:0] red_c;

    wmul_ppgen #(.W(W), .NPP(NPP)) u_ppgen (
        .a_i  (a_i),
        .b_i  (b_i),
        .pp_o (pp)
    );

    wmul_tree #(.W(W), .NIN(NPP)) u_tree (
        .in_i  (pp),
        .sum_o (red_s),
        .cry_o (red_c)
    );

    // Final carry-propagate addition, truncated to W bits
    assign prod_o = red_s + red_c;

    always_comb begin
        if ((a_i == '0) || (b_i == '0)) begin
            AST_ZERO_OPERAND: assert (prod_o == '0); // R4
        end
        if (b_i == W'(1)) begin
            AST_UNIT_MULTIPLIER: assert (prod_o == a_i); // R5
        end
        if (b_i == W'(2)) begin
            AST_DOUBLE_DROP: assert (prod_o == {a_i[W-2:0], 1'b0}); // R8
        end
    end
endmodule

// File: tb/wallace_mul32_tb.sv
module wallace_mul32_tb;
    logic        clk;
    logic        rst;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] prod;

    logic [7:0]  cx, cy, cz, cs, cc;

    int n_chk;
    int n_fail;
    int cyc;
    bit done;

    wallace_mul32 u_dut (
        .a_i    (a),
        .b_i    (b),
        .prod_o (prod)
    );

    wmul_csa #(.W(8)) u_csa8 (
        .x_i   (cx),
        .y_i   (cy),
        .z_i   (cz),
        .sum_o (cs),
        .cry_o (cc)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 100000", cyc);
            report();
        end
    end

    function automatic logic [31:0] ref_u(input logic [31:0] x, input logic [31:0] y);
        longint unsigned p;
        p = longint'(x) * longint'(y);
        return p[31:0];
    endfunction

    function automatic logic [31:0] ref_s(input logic [31:0] x, input logic [31:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: a=%h b=%h actual %h expected %h", req, a, b, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns later, before the next rising edge
    task automatic apply(input string req, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        a = x;
        b = y;
        #1;
        check(req, prod, ref_u(x, y));
    endtask

    initial begin
        logic [31:0] corner [5];
        n_chk  = 0;
        n_fail = 0;
        cyc    = 0;
        done   = 0;
        rst    = 1'b1;
        a = '0; b = '0;
        cx = '0; cy = '0; cz = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: zero operands give zero (R4)
        @(negedge clk);
        check("R4 idle", prod, 32'd0);

        // R7: carry-save cell split on the 40/41/42 vector
        cx = 8'd40; cy = 8'd41; cz = 8'd42;
        #1;
        n_chk = n_chk + 2;
        if (cs !== 8'd43) begin
            n_fail = n_fail + 1;
            $display("FAIL R7 sum: actual %0d expected 43", cs);
        end
        if (cc !== 8'd80) begin
            n_fail = n_fail + 1;
            $display("FAIL R7 carry: actual %0d expected 80", cc);
        end

        // R4: zero on either side
        apply("R4", 32'hDEADBEEF, 32'h0);
        apply("R4", 32'h0, 32'hFFFFFFFF);

        // R5: powers of two shift the multiplicand
        for (int k = 0; k < 32; k++) begin
            apply("R5", 32'hA5C3_0F96, 32'd1 << k);
        end

        // R6: field value 3 selects the triple
        apply("R6", 32'h1234_5678, 32'd3);
        apply("R6", 32'h5555_5555, 32'h3000_0000);

        // R8: truncation at the top
        apply("R8", 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R8 allones", prod, 32'd1);
        apply("R8", 32'h80000000, 32'd2);
        check("R8 msb", prod, 32'd0);

        // R1: corner values crossed with each other
        corner[0] = 32'h0;
        corner[1] = 32'h1;
        corner[2] = 32'hFFFFFFFF;
        corner[3] = 32'h80000000;
        corner[4] = 32'h7FFFFFFF;
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                apply("R1 corner", corner[i], corner[j]);
            end
        end

        // R9: repeating field patterns
        apply("R9", 32'h0BAD_F00D, 32'hE4E4E4E4);
        apply("R9", 32'hFEDC_BA98, 32'h1B1B1B1B);
        apply("R9", 32'h7FFFFFFF, 32'hAAAAAAAA);
        apply("R9", 32'h3C3C3C3C, 32'hFFFF0000);

        // R2: signed operands, compared to the signed reference
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            a = $urandom() | 32'h80000000;
            b = (i % 2 == 0) ? ($urandom() | 32'h80000000) : ($urandom() & 32'h7FFFFFFF);
            #1;
            check("R2 signed", prod, ref_s(a, b));
        end

        // R3: back-to-back operands, no clock edge between drive and sample
        @(negedge clk);
        a = 32'd7; b = 32'd9;
        #0.5;
        check("R3 first", prod, 32'd63);
        a = 32'hFFFF_FFFE; b = 32'd5;
        #0.5;
        check("R3 second", prod, ref_u(32'hFFFF_FFFE, 32'd5));

        // R1: random operands, one per clock
        for (int i = 0; i < 400; i++) begin
            apply("R1 random", $urandom(), $urandom());
        end

        done = 1;
        report();
    end
endmodule